// File: doc/BRIEF.md
# Fetch-Source Memory Access Guard

This block sits between a processor's operand path and the on-chip memories. It compares every operand read or write against a protection byte, and the answer depends on two things: the region the operand address falls in, and the region the current instruction was fetched from. An access that is allowed passes its strobe and read data through unchanged. An access that is denied has its strobe blocked in the same cycle, returns zero read data, and produces a violation pulse one cycle later.

After reset the guard accepts a single configuration byte. That byte is the protection value read from non-volatile storage during start-up. Until that byte arrives, and for the whole of reset, every protection is treated as active. Writes to the code part of the test-flash region are always refused. The last 128 bytes of that region hold the protection and password registers, and they follow the test-flash access rule.

Top module: `fetch_access_guard`

## Requirements
- R1: While reset is asserted, and after reset until a configuration byte is accepted, decisions are made as if the protection byte were 00h. The violation output is low during reset.
- R2: The first cycle after reset with `cfg_load` high latches `cfg_byte`. The latched value governs decisions from the next cycle on. Any later `cfg_load` is ignored until the next reset.
- R3: Flash protection is active when bit 6 of the byte is 0. It then denies operand accesses to the flash region unless the fetch tag is test-flash (0) or flash (1).
- R4: Test-flash protection is active when bit 5 is 0. It then denies operand accesses to the whole test-flash region, including the register block 231F80h..231FFFh, unless the fetch tag is test-flash (0).
- R5: EEPROM protection is active when bit 4 is 0. It then denies operand accesses to the EEPROM region unless the fetch tag is test-flash (0), flash (1) or EEPROM (2).
- R6: External-fetch protection is active when bit 3 is 0. It then denies operand accesses to any internal region (test-flash, flash, EEPROM, RAM) when the fetch tag is external (4). Tags 5 to 7 are treated as external by every rule.
- R7: Writes to 230000h..231F7Fh are denied whatever the protection byte holds.
- R8: On a denied access, `mem_rd`, `mem_wr` and `grant` are low in the same cycle and `op_rdata` is 0. On an allowed access, the strobes follow `op_rd` and `op_wr`, `grant` is high, and `op_rdata` equals `mem_rdata`.
- R9: `viol` is high for exactly the cycle that follows each cycle holding a denied access, and low otherwise. A cycle with neither strobe is never denied.
- R10: Bits 7 and 2..0 of the configuration byte have no effect on any decision.
- R11: Default address map: flash 010000h..0FFFFFh, RAM 200000h..200FFFh, EEPROM 220000h..2203FFh, test-flash 230000h..231FFFh. Every other address is external. Fetch tags: 0 test-flash, 1 flash, 2 EEPROM, 3 RAM, 4 external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Request to latch the protection byte |
| cfg_byte | input | 8 | Protection byte (active-low protection bits) |
| op_addr | input | 24 | Operand address |
| op_rd | input | 1 | Operand read strobe |
| op_wr | input | 1 | Operand write strobe |
| fetch_src | input | 3 | Region tag of the current instruction's fetch |
| mem_rdata | input | 8 | Read data from the memories |
| mem_rd | output | 1 | Read strobe passed to the memories |
| mem_wr | output | 1 | Write strobe passed to the memories |
| op_rdata | output | 8 | Read data returned to the operand path |
| grant | output | 1 | Access with a strobe was allowed |
| viol | output | 1 | Registered violation pulse |

## Verification
The strobes, `grant` and `op_rdata` are combinational, so they are due in the same cycle as the access. The bench samples them at the falling edge that follows input changes made just after a rising edge. `viol` and the configuration latch are both registered. The bench's reference model updates its own copies at the rising edge, using the inputs present before that edge, so the expected pulse lines up with the cycle after the denied access and a newly loaded byte takes effect one cycle after it is accepted. Directed checks on the write lock, ignored reloads and the violation pulse read the outputs one time step after the relevant edge.

// File: rtl/fag_pkg.sv
package fag_pkg;
    typedef enum logic [2:0] {
        SRC_TFLASH = 3'd0,
        SRC_FLASH  = 3'd1,
        SRC_EEPROM = 3'd2,
        SRC_RAM    = 3'd3,
        SRC_EXT    = 3'd4
    } region_e;

    localparam int CFG_W   = 8;
    localparam int BIT_FLP = 6;
    localparam int BIT_TFP = 5;
    localparam int BIT_EEP = 4;
    localparam int BIT_XFP = 3;

    typedef struct packed {
        logic [CFG_W-1:0] prot;
        logic             loaded;
        logic             viol;
    } guard_state_t;
endpackage

// File: rtl/fag_region_decode.sv
module fag_region_decode
    import fag_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] FLASH_LO = 24'h010000,
    parameter logic [ADDR_W-1:0] FLASH_HI = 24'h0FFFFF,
    parameter logic [ADDR_W-1:0] RAM_LO   = 24'h200000,
    parameter logic [ADDR_W-1:0] RAM_HI   = 24'h200FFF,
    parameter logic [ADDR_W-1:0] EE_LO    = 24'h220000,
    parameter logic [ADDR_W-1:0] EE_HI    = 24'h2203FF,
    parameter logic [ADDR_W-1:0] TF_LO    = 24'h230000,
    parameter logic [ADDR_W-1:0] TF_HI    = 24'h231FFF,
    parameter logic [ADDR_W-1:0] TF_WP_HI = 24'h231F7F
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn,
    output logic              wlock
);
    always_comb begin
        if (addr >= TF_LO && addr <= TF_HI)         rgn = SRC_TFLASH;
        else if (addr >= EE_LO && addr <= EE_HI)    rgn = SRC_EEPROM;
        else if (addr >= RAM_LO && addr <= RAM_HI)  rgn = SRC_RAM;
        else if (addr >= FLASH_LO && addr <= FLASH_HI) rgn = SRC_FLASH;
        else                                        rgn = SRC_EXT;
        wlock = (addr >= TF_LO) && (addr <= TF_WP_HI);
    end
endmodule

// File: rtl/fag_rule_eval.sv
module fag_rule_eval
    import fag_pkg::*;
(
    input  region_e          rgn,
    input  logic [2:0]       src_raw,
    input  logic [CFG_W-1:0] prot_eff,
    input  logic             wlock,
    input  logic             rd,
    input  logic             wr,
    output logic             deny
);
    region_e src;
    logic    internal_tgt;
    logic    fl_hit, tf_hit, ee_hit, xf_hit, wl_hit;

    always_comb begin
        // Unknown tags fall to the most restrictive source.
        src = (src_raw > 3'd4) ? SRC_EXT : region_e'(src_raw);
        internal_tgt = (rgn != SRC_EXT);

        fl_hit = !prot_eff[BIT_FLP] && (rgn == SRC_FLASH)
                 && !(src == SRC_TFLASH || src == SRC_FLASH);
        tf_hit = !prot_eff[BIT_TFP] && (rgn == SRC_TFLASH)
                 && (src != SRC_TFLASH);
        ee_hit = !prot_eff[BIT_EEP] && (rgn == SRC_EEPROM)
                 && !(src == SRC_TFLASH || src == SRC_FLASH || src == SRC_EEPROM);
        xf_hit = !prot_eff[BIT_XFP] && internal_tgt && (src == SRC_EXT);
        wl_hit = wr && wlock;

        deny = (rd || wr) && (fl_hit || tf_hit || ee_hit || xf_hit || wl_hit);
    end
endmodule

// File: rtl/fetch_access_guard.sv
module fetch_access_guard
    import fag_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] FLASH_LO   = 24'h010000,
    parameter logic [ADDR_W-1:0] FLASH_HI   = 24'h0FFFFF,
    parameter logic [ADDR_W-1:0] RAM_LO     = 24'h200000,
    parameter logic [ADDR_W-1:0] RAM_HI     = 24'h200FFF,
    parameter logic [ADDR_W-1:0] EE_LO      = 24'h220000,
    parameter logic [ADDR_W-1:0] EE_HI      = 24'h2203FF,
    parameter logic [ADDR_W-1:0] TF_LO      = 24'h230000,
    parameter logic [ADDR_W-1:0] TF_HI      = 24'h231FFF,
    parameter int                TF_REG_SPAN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_byte,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_rd,
    input  logic              op_wr,
    input  logic [2:0]        fetch_src,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] op_rdata,
    output logic              grant,
    output logic              viol
);
    localparam logic [ADDR_W-1:0] TF_WP_HI = TF_HI - ADDR_W'(TF_REG_SPAN);

    guard_state_t     st_q, st_d;
    logic [CFG_W-1:0] prot_eff;
    logic             cfg_loaded;
    logic [CFG_W-1:0] cfg_prot;
    region_e          tgt_rgn;
    logic             wlock;
    logic             deny;

    assign cfg_loaded = st_q.loaded;
    assign cfg_prot   = st_q.prot;

    fag_region_decode #(
        .ADDR_W(ADDR_W), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI),
        .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .EE_LO(EE_LO), .EE_HI(EE_HI),
        .TF_LO(TF_LO), .TF_HI(TF_HI), .TF_WP_HI(TF_WP_HI)
    ) u_decode (
        .addr (op_addr),
        .rgn  (tgt_rgn),
        .wlock(wlock)
    );

    fag_rule_eval u_rules (
        .rgn     (tgt_rgn),
        .src_raw (fetch_src),
        .prot_eff(prot_eff),
        .wlock   (wlock),
        .rd      (op_rd),
        .wr      (op_wr),
        .deny    (deny)
    );

    always_comb begin
        // Until a byte is latched every protection bit reads as active.
        prot_eff = st_q.loaded ? st_q.prot : '0;

        st_d = st_q;
        if (cfg_load && !st_q.loaded) begin
            st_d.prot   = cfg_byte;
            st_d.loaded = 1'b1;
        end
        st_d.viol = deny;

        mem_rd   = op_rd && !deny;
        mem_wr   = op_wr && !deny;
        grant    = (op_rd || op_wr) && !deny;
        op_rdata = mem_rd ? mem_rdata : '0;
        viol     = st_q.viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prot: '0, loaded: 1'b0, viol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] RAM_LO   = 24'h200000,
    parameter logic [ADDR_W-1:0] RAM_HI   = 24'h200FFF,
    parameter logic [ADDR_W-1:0] TF_LO    = 24'h230000,
    parameter logic [ADDR_W-1:0] TF_WP_HI = 24'h231F7F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] op_addr,
    input logic              op_rd,
    input logic              op_wr,
    input logic [2:0]        fetch_src,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              grant,
    input logic              viol,
    input logic              loaded,
    input logic [7:0]        prot
);
    // R8
    blocked_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_rd || op_wr) && !grant) |-> (!mem_rd && !mem_wr));

    // R9
    viol_after_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_rd || op_wr) && !grant) |=> viol);

    // R9
    no_spurious_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(op_rd || op_wr) || grant) |=> !viol);

    // R7
    tf_write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_addr >= TF_LO && op_addr <= TF_WP_HI) |-> !mem_wr);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && $past(loaded)) |-> $stable(prot));

    // R1
    unloaded_ext_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded && op_rd && fetch_src == 3'd4 && op_addr >= RAM_LO
         && op_addr <= RAM_HI) |-> !mem_rd);
endmodule

bind fetch_access_guard fag_checker #(
    .ADDR_W(ADDR_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
    .TF_LO(TF_LO), .TF_WP_HI(TF_WP_HI)
) u_fag_chk (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .op_rd(op_rd),
    .op_wr(op_wr), .fetch_src(fetch_src), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .grant(grant), .viol(viol),
    .loaded(cfg_loaded), .prot(cfg_prot)
);

// File: tb/test_fetch_access_guard.sv
`timescale 1ns/1ps
module test_fetch_access_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_byte = 8'h00;
    logic [23:0] op_addr = 24'h0;
    logic        op_rd = 1'b0, op_wr = 1'b0;
    logic [2:0]  fetch_src = 3'd0;
    logic [7:0]  mem_rdata;
    logic        mem_rd, mem_wr, grant, viol;
    logic [7:0]  op_rdata;

    int    total = 0, bad = 0;
    bit    done = 0;
    string cur = "R1";

    logic [7:0] m_prot = 8'h00;
    bit         m_loaded = 0;
    bit         m_viol = 0;

    assign mem_rdata = op_addr[7:0] ^ 8'h5A;

    always #2.5 clk = ~clk;

    fetch_access_guard i_fetch_access_guard (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_byte(cfg_byte),
        .op_addr(op_addr), .op_rd(op_rd), .op_wr(op_wr), .fetch_src(fetch_src),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .op_rdata(op_rdata), .grant(grant), .viol(viol)
    );

    // Region code from the R11 map: 0 TF, 1 flash, 2 EEPROM, 3 RAM, 4 external.
    function automatic int region_of(logic [23:0] a);
        if (a >= 24'h230000 && a <= 24'h231FFF) return 0;
        if (a >= 24'h010000 && a <= 24'h0FFFFF) return 1;
        if (a >= 24'h220000 && a <= 24'h2203FF) return 2;
        if (a >= 24'h200000 && a <= 24'h200FFF) return 3;
        return 4;
    endfunction

    function automatic bit ref_deny(logic [23:0] a, bit rd, bit wr, int s_in,
                                    logic [7:0] p, bit ld);
        logic [7:0] e;
        int r, s;
        bit allowed[5];
        if (!rd && !wr) return 0;
        e = ld ? p : 8'h00;
        s = (s_in > 4) ? 4 : s_in;
        r = region_of(a);
        if (wr && a >= 24'h230000 && a <= 24'h231F7F) return 1;   // R7
        if (r == 4) return 0;
        if (!e[3] && s == 4) return 1;                               // R6
        // Allowed fetch sources for each protected region.
        for (int k = 0; k < 5; k++) allowed[k] = 1;
        if (r == 1 && !e[6]) begin for (int k = 2; k < 5; k++) allowed[k] = 0; end  // R3
        if (r == 0 && !e[5]) begin for (int k = 1; k < 5; k++) allowed[k] = 0; end  // R4
        if (r == 2 && !e[4]) begin allowed[3] = 0; allowed[4] = 0; end              // R5
        return !allowed[s];
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference state advances on the same edges as the design.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prot <= 8'h00; m_loaded <= 0; m_viol <= 0;
        end else begin
            m_viol <= ref_deny(op_addr, op_rd, op_wr, int'(fetch_src), m_prot, m_loaded);
            if (cfg_load && !m_loaded) begin
                m_prot <= cfg_byte; m_loaded <= 1;
            end
        end
    end

    // Every-cycle comparison (R8, R9 plus the phase's own requirement).
    always @(negedge clk) begin
        bit d;
        d = ref_deny(op_addr, op_rd, op_wr, int'(fetch_src), m_prot, m_loaded);
        chk(cur, "mem_rd", mem_rd, op_rd && !d);
        chk(cur, "mem_wr", mem_wr, op_wr && !d);
        chk(cur, "grant", grant, (op_rd || op_wr) && !d);
        chk(cur, "op_rdata", op_rdata, (op_rd && !d) ? mem_rdata : 8'h00);
        chk("R9", "viol", viol, m_viol);
    end

    task automatic acc(logic [23:0] a, bit rd, bit wr, int s);
        @(posedge clk); #1;
        op_addr = a; op_rd = rd; op_wr = wr; fetch_src = 3'(s);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        op_rd = 0; op_wr = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0; op_rd = 0; op_wr = 0; cfg_load = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic load(logic [7:0] b);
        @(posedge clk); #1;
        cfg_load = 1; cfg_byte = b;
        @(posedge clk); #1;
        cfg_load = 0;
    endtask

    task automatic sweep();
        logic [23:0] pts[14] = '{24'h010000, 24'h0FFFFF, 24'h00FFFF, 24'h100000,
                                 24'h200000, 24'h200FFF, 24'h220000, 24'h2203FF,
                                 24'h230000, 24'h231F7F, 24'h231F80, 24'h231FFC,
                                 24'h231FFF, 24'hFFFFFF};
        for (int i = 0; i < 14; i++)
            for (int s = 0; s < 8; s++)
                for (int k = 0; k < 2; k++)
                    acc(pts[i], k == 0, k == 1, s);
        idle();
    endtask

    initial begin
        // R1: decisions during reset use all protections
        cur = "R1";
        acc(24'h200010, 1, 0, 4);
        #1 chk("R1", "ext fetch to RAM in reset blocked", mem_rd, 0);
        acc(24'h050000, 1, 0, 3);
        #1 chk("R1", "RAM fetch to flash in reset blocked", mem_rd, 0);
        @(posedge clk); #1 chk("R1", "viol low in reset", viol, 0);
        idle();
        #1 rst_n = 1;
        cur = "R1";
        sweep();

        // R2: first load wins, later load ignored
        cur = "R2";
        load(8'hFF);
        load(8'h00);
        acc(24'h200010, 1, 0, 4);
        #1 chk("R2", "reload ignored, ext read of RAM allowed", mem_rd, 1);
        acc(24'h231FFC, 0, 1, 3);
        #1 chk("R4", "reg block write allowed when TF prot off", mem_wr, 1);
        cur = "R7";
        acc(24'h230010, 0, 1, 0);
        #1 chk("R7", "TF code write blocked with prot off", mem_wr, 0);
        @(posedge clk); #1 chk("R9", "viol after blocked write", viol, 1);
        op_wr = 0;
        @(posedge clk); #1 chk("R9", "viol single pulse", viol, 0);
        sweep();

        cur = "R3"; do_reset(); load(8'hBF); sweep();
        acc(24'h020000, 1, 0, 2);
        #1 chk("R3", "EEPROM fetch to flash blocked", mem_rd, 0);
        acc(24'h020000, 1, 0, 1);
        #1 chk("R3", "flash fetch to flash allowed", mem_rd, 1);
        chk("R8", "read data passed", op_rdata, 8'h5A);

        cur = "R4"; do_reset(); load(8'hDF); sweep();
        acc(24'h231FFD, 1, 0, 1);
        #1 chk("R4", "flash fetch to reg block blocked", mem_rd, 0);
        chk("R8", "blocked read returns zero", op_rdata, 0);

        cur = "R5"; do_reset(); load(8'hEF); sweep();
        acc(24'h220100, 0, 1, 3);
        #1 chk("R5", "RAM fetch write to EEPROM blocked", mem_wr, 0);

        cur = "R6"; do_reset(); load(8'hF7); sweep();
        acc(24'h200100, 1, 0, 6);
        #1 chk("R6", "tag 6 treated as external", mem_rd, 0);

        cur = "R10"; do_reset(); load(8'h78); sweep();
        acc(24'h200100, 1, 0, 4);
        #1 chk("R10", "low/high bits ignored, ext read allowed", mem_rd, 1);
        cur = "R10"; do_reset(); load(8'h87); sweep();

        cur = "R11"; do_reset(); load(8'h00); sweep();
        acc(24'h00FFFF, 1, 0, 4);
        #1 chk("R11", "below flash is external, allowed", mem_rd, 1);

        idle();
        @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule